// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs single transfers on an external bus where the low address byte and the data byte share one set of eight pins, and the high address byte has its own pins. Each request becomes a fixed three-state bus cycle (T1, T2, T3). In T1 an address strobe marks the address phase on the shared pins. In T2 and T3 those pins carry data: they are driven by the block for a write and released for a read. A memory/I-O select pin qualifies the read and write strobes. From these, the block also decodes four separate active-low command strobes: memory read, memory write, I/O read and I/O write.

Requests arrive on a valid/ready port. `req_ready` is high only while no bus cycle is running. A request is taken on the rising clock edge where `req_valid` and `req_ready` are both high. A request that is presented while a cycle runs is not taken and has no effect. The completion side has no back-pressure: `done` is a single-cycle pulse, and `rdata` holds the last read byte until the next read completes. For checking, the block includes a behavioural model of the external transparent latch that holds the low address byte once the address strobe drops.

Top module: `muxbus_cycle_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no bus cycle is in T1–T3. A request is taken on an edge with `req_valid` and `req_ready` both high, and T1 begins in the next cycle.
- R2: Every cycle lasts exactly three clocks (T1, T2, T3). `busy` is high in those three clocks and low otherwise.
- R3: In T1, `ale` is 1, `ad_oe` is 1, `ad_out` is address bits 7:0 and `addr_hi` is address bits 15:8. `ale` is 0 in every other cycle. `addr_hi` holds the last address high byte between cycles (0 after reset).
- R4: `latched_lo` loads `ad_out` while `ale` is high and otherwise holds. From T2 onward it equals the address low byte of the current cycle (0 after reset).
- R5: `io_m` equals the request's I-O flag (1 = I/O, 0 = memory) from T1 through T3. It holds that value until the next request is taken (0 after reset).
- R6: On a read (`req_write` = 0), `rd_n` is 0 in T2 and T3 and `ad_oe` is 0 in T2 and T3.
- R7: On a write (`req_write` = 1), `wr_n` is 0 in T2 and T3, `ad_oe` is 1 and `ad_out` equals the write data in T2 and T3.
- R8: `rd_n` and `wr_n` are never low together. Both are 1 outside T2–T3.
- R9: The strobes are active low. `memr_n` is low iff `rd_n`=0 and `io_m`=0. `memw_n` is low iff `wr_n`=0 and `io_m`=0. `ior_n` is low iff `rd_n`=0 and `io_m`=1. `iow_n` is low iff `wr_n`=0 and `io_m`=1.
- R10: `done` is 1 for exactly the one cycle after T3. On a read, `rdata` then equals `ad_in` as it stood at the clock edge ending T3, and it holds until the next read ends. A write leaves `rdata` unchanged.
- R11: A request presented while `busy` is high is ignored. The running cycle's address, data and strobes are unchanged, and no further cycle starts unless `req_valid` is still high once idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_addr | input | 16 | Bus address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | High during T1–T3 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read byte |
| ale | output | 1 | Address phase strobe |
| addr_hi | output | 8 | Upper address byte pins |
| ad_out | output | 8 | Shared pins, outgoing value |
| ad_oe | output | 1 | Shared pins driver enable |
| ad_in | input | 8 | Shared pins, incoming value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| memr_n | output | 1 | Memory read command, active low |
| memw_n | output | 1 | Memory write command, active low |
| ior_n | output | 1 | I/O read command, active low |
| iow_n | output | 1 | I/O write command, active low |
| latched_lo | output | 8 | Model of external low-address latch |

## Verification
After the edge that takes a request, T1 pins appear one cycle later. The latch output and the T2 data/read strobes appear two cycles later, and `done` with `rdata` appears four cycles later, in the idle cycle after T3. The bench keeps a behavioural phase counter that advances on the same edges. It drives inputs and compares every output on each falling clock edge, so each expected value is checked in the exact cycle it is due and in no other. The read byte on `ad_in` changes every cycle, so a sample taken one cycle early or late shows up as a mismatch.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned HI_W  = ADDR_W - DATA_W;
  localparam int unsigned N_STROBE = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } tphase_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              write;
    logic              io;
    logic [DATA_W-1:0] wdata;
  } bus_req_t;
endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  bus_req_t          req_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic              req_ready,
  output tphase_e           phase,
  output bus_req_t          cur,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  tphase_e phase_nxt;
  logic    accept;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE: if (accept) phase_nxt = PH_T1;
      PH_T1:   phase_nxt = PH_T2;
      PH_T2:   phase_nxt = PH_T3;
      PH_T3:   phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cur   <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      phase <= phase_nxt;
      done  <= (phase == PH_T3);
      if (accept) cur <= req_in;
      if (phase == PH_T3 && !cur.write) rdata <= ad_in;
    end
  end

  a_r1_t1_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (phase == PH_T1));
  a_r2_three_tstates: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1) |=> (phase == PH_T2) ##1 (phase == PH_T3) ##1 (phase == PH_IDLE));
  a_r10_done_after_t3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T3) |=> (done && phase == PH_IDLE));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_T3) |=> $stable(rdata));
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(cur));
endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins
  import muxbus_pkg::*;
(
  input  tphase_e               phase,
  input  bus_req_t              cur,
  output logic                  ale,
  output logic [HI_W-1:0]       addr_hi,
  output logic [DATA_W-1:0]     ad_out,
  output logic                  ad_oe,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic                  io_m,
  output logic [N_STROBE-1:0]   strobe_n
);
  logic data_ph;
  logic wr_drive;

  assign data_ph  = (phase == PH_T2) || (phase == PH_T3);
  assign wr_drive = data_ph && cur.write;

  assign ale     = (phase == PH_T1);
  assign addr_hi = cur.addr[ADDR_W-1:DATA_W];
  assign ad_oe   = ale || wr_drive;
  assign rd_n    = !(data_ph && !cur.write);
  assign wr_n    = !wr_drive;
  assign io_m    = cur.io;

  always_comb begin
    if (ale)           ad_out = cur.addr[DATA_W-1:0];
    else if (wr_drive) ad_out = cur.wdata;
    else               ad_out = '0;
  end

  // strobe index {space, direction}: 0 mem rd, 1 mem wr, 2 io rd, 3 io wr
  for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
    localparam logic SPACE = 1'((g >> 1) & 1);
    localparam logic DIR   = 1'(g & 1);
    if (DIR) begin : g_wr
      assign strobe_n[g] = !((io_m == SPACE) && !wr_n);
    end else begin : g_rd
      assign strobe_n[g] = !((io_m == SPACE) && !rd_n);
    end
  end
endmodule

// File: rtl/muxbus_addr_latch.sv
module muxbus_addr_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (le) q <= d;
  end

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (q == $past(d)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> $stable(q));
endmodule

// File: rtl/muxbus_cycle_ctrl.sv
module muxbus_cycle_ctrl
  import muxbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic [DATA_W-1:0] latched_lo
);
  bus_req_t            req_in;
  bus_req_t            cur;
  tphase_e             phase;
  logic [N_STROBE-1:0] strobe_n;

  assign req_in = '{addr: req_addr, write: req_write, io: req_io, wdata: req_wdata};
  assign busy   = (phase != PH_IDLE);

  muxbus_seq u_seq (
    .clk, .rst_n, .req_valid, .req_in, .ad_in,
    .req_ready, .phase, .cur, .done, .rdata
  );

  muxbus_pins u_pins (
    .phase, .cur, .ale, .addr_hi, .ad_out, .ad_oe,
    .rd_n, .wr_n, .io_m, .strobe_n
  );

  muxbus_addr_latch #(.W(DATA_W)) u_latch (
    .clk, .rst_n, .le(ale), .d(ad_out), .q(latched_lo)
  );

  assign memr_n = strobe_n[0];
  assign memw_n = strobe_n[1];
  assign ior_n  = strobe_n[2];
  assign iow_n  = strobe_n[3];

  a_r1_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 !busy);
  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  a_r3_ale_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && busy && rd_n && wr_n));
  a_r5_iom_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(io_m));
  a_r6_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe && busy));
  a_r7_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && busy));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~strobe_n));
  a_r9_mem_read: assert property (@(posedge clk) disable iff (!rst_n)
    !memr_n |-> (!rd_n && !io_m));
  a_r9_io_write: assert property (@(posedge clk) disable iff (!rst_n)
    !iow_n |-> (!wr_n && io_m));
endmodule

// File: tb/muxbus_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module muxbus_cycle_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0;
  logic req_ready, busy, done, ale, ad_oe, rd_n, wr_n, io_m;
  logic memr_n, memw_n, ior_n, iow_n;
  logic [7:0] rdata, addr_hi, ad_out, latched_lo;

  always #2 clk = ~clk;

  muxbus_cycle_ctrl u_muxbus_cycle_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write, .req_io,
    .req_wdata, .busy, .done, .rdata, .ale, .addr_hi, .ad_out, .ad_oe,
    .ad_in, .rd_n, .wr_n, .io_m, .memr_n, .memw_n, .ior_n, .iow_n, .latched_lo
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int         m_ph = 0;
  logic [15:0] m_addr = '0;
  logic        m_wr = 1'b0, m_io = 1'b0, m_done = 1'b0;
  logic [7:0]  m_wd = '0, m_rdata = '0, m_latch = '0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  task automatic compare();
    logic e_rd, e_wr, e_oe;
    e_rd = !(m_ph >= 2 && !m_wr);
    e_wr = !(m_ph >= 2 && m_wr);
    e_oe = (m_ph == 1) || (m_ph >= 2 && m_wr);
    chk("R1", "req_ready", 16'(req_ready), 16'(m_ph == 0));
    chk("R2", "busy", 16'(busy), 16'(m_ph != 0));
    chk("R3", "ale", 16'(ale), 16'(m_ph == 1));
    chk("R3/R11", "addr_hi", 16'(addr_hi), 16'(m_addr[15:8]));
    chk("R6/R7", "ad_oe", 16'(ad_oe), 16'(e_oe));
    if (m_ph == 1) chk("R3/R11", "ad_out addr", 16'(ad_out), 16'(m_addr[7:0]));
    if (m_ph >= 2 && m_wr) chk("R7", "ad_out data", 16'(ad_out), 16'(m_wd));
    chk("R6", "rd_n", 16'(rd_n), 16'(e_rd));
    chk("R7", "wr_n", 16'(wr_n), 16'(e_wr));
    chk("R8", "rd_n&wr_n low", 16'(!rd_n && !wr_n), 16'(0));
    chk("R5", "io_m", 16'(io_m), 16'(m_io));
    chk("R9", "memr_n", 16'(memr_n), 16'(!(!e_rd && !m_io)));
    chk("R9", "memw_n", 16'(memw_n), 16'(!(!e_wr && !m_io)));
    chk("R9", "ior_n", 16'(ior_n), 16'(!(!e_rd && m_io)));
    chk("R9", "iow_n", 16'(iow_n), 16'(!(!e_wr && m_io)));
    chk("R10", "done", 16'(done), 16'(m_done));
    chk("R10", "rdata", 16'(rdata), 16'(m_rdata));
    chk("R4", "latched_lo", 16'(latched_lo), 16'(m_latch));
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic w,
                      input logic io, input logic [7:0] wd);
    int old_ph;
    @(negedge clk);
    cyc++;
    compare();
    req_valid = v; req_addr = a; req_write = w; req_io = io; req_wdata = wd;
    ad_in = 8'(cyc * 37 + 11);
    old_ph = m_ph;
    m_done = (old_ph == 3);
    case (old_ph)
      0: if (v) begin
           m_addr = a; m_wr = w; m_io = io; m_wd = wd; m_ph = 1;
         end
      1: begin m_latch = m_addr[7:0]; m_ph = 2; end
      2: m_ph = 3;
      default: begin
        if (!m_wr) m_rdata = ad_in;
        m_ph = 0;
      end
    endcase
  endtask

  task automatic run_cycle(input logic [15:0] a, input logic w, input logic io, input logic [7:0] wd);
    step(1'b1, a, w, io, wd);
    repeat (4) step(1'b0, 16'h5555, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(); // reset state, R1 R2 R4 R5 R10
    rst_n = 1'b1;
    step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0);
    run_cycle(16'h1234, 1'b0, 1'b0, 8'h00); // mem read  R6 R10
    run_cycle(16'hABCD, 1'b1, 1'b0, 8'h5A); // mem write R7
    run_cycle(16'h0042, 1'b0, 1'b1, 8'h00); // io read   R9
    run_cycle(16'h00FF, 1'b1, 1'b1, 8'hA5); // io write  R9
    run_cycle(16'hFFFF, 1'b0, 1'b0, 8'h00); // boundary
    run_cycle(16'h0000, 1'b1, 1'b1, 8'hFF); // boundary
    run_cycle(16'hFF00, 1'b0, 1'b1, 8'h00);
    // R1 back-to-back: valid held, a new cycle starts at each idle slot
    for (int i = 0; i < 14; i++)
      step(1'b1, 16'(16'h3000 + i * 16'h0111), 1'(i & 1), 1'(i >> 1 & 1), 8'(i * 17));
    repeat (3) step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0);
    // R11 requests during T1..T3 are ignored
    step(1'b1, 16'h8421, 1'b1, 1'b0, 8'h3C);
    step(1'b1, 16'h7E7E, 1'b0, 1'b1, 8'hC3);
    step(1'b1, 16'h1111, 1'b0, 1'b1, 8'h99);
    step(1'b1, 16'h2222, 1'b0, 1'b1, 8'h77);
    repeat (5) step(1'b0, 16'h4444, 1'b0, 1'b1, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired at cycle %0d actual hang expected finish", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule